// File: doc/BRIEF.md
# Index-Initialised General Register File

This block is the general-purpose register array of a small single-cycle processor datapath. It holds 32 words of 32 bits. Two operand words can be read at the same time through independent read ports, and one result word can be written on each rising clock edge. Both read ports are combinational, so operands are ready within the cycle in which their addresses are presented.

When the active-low reset is asserted, the reset is asynchronous. Each entry is loaded with its own address as a value: entry 0 holds 0, entry 1 holds 1, and so on. A test program can therefore compute with known operands without first loading any of them. A dedicated output always mirrors one fixed entry (entry 1 by default). A display or an observer can watch a result there without using a read port. Entry 0 is an ordinary storage location and is not tied to zero.

The depth, the word width, the mirrored entry and the construction of the read multiplexer are all parameters. Elaboration checks reject configurations the array cannot support.

Top module: `idx_regfile`

## Requirements
- R1: The array holds 32 separate 32-bit entries, addressed 0 to 31 by a 5-bit address, and each address selects its own storage.
- R2: The two read ports are combinational and independent. `rd_data_a` shows the entry at `rd_addr_a` and `rd_data_b` shows the entry at `rd_addr_b` in the same cycle, and both show the same value when the addresses are equal.
- R3: When `wr_en` is 1 at a rising clock edge, `wr_data` is stored into the entry at `wr_addr`, and no other entry changes.
- R4: When `wr_en` is 0 at a rising clock edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R5: While `rst_n` is 0, every entry i holds the value i, zero-extended to 32 bits. The load happens at once when `rst_n` falls, without waiting for a clock edge, and it overrides any write requested during reset.
- R6: `probe_data` always equals the contents of entry 1.
- R7: Entry 0 can be written and read back like any other entry.
- R8: If a read port addresses the entry that is being written in the same cycle, it returns the old contents until the rising edge and the new contents after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads entry i with i |
| rd_addr_a | input | 5 | Address for read port A |
| rd_addr_b | input | 5 | Address for read port B |
| wr_addr | input | 5 | Address of the entry to write |
| wr_data | input | 32 | Word to write |
| wr_en | input | 1 | Write enable, active high |
| rd_data_a | output | 32 | Contents of the entry at `rd_addr_a` |
| rd_data_b | output | 32 | Contents of the entry at `rd_addr_b` |
| probe_data | output | 32 | Continuous copy of entry 1 |

## Verification
After reset, every address is read on both ports at once, with port B walking downward while port A walks upward. This separates a correct index load from a zero load and from crossed read ports. A full write sweep then gives each entry a value that differs from its index and from its neighbours. Reading the sweep back tells a correct write decode apart from aliased or shifted addresses, including the entry-0 case. A sweep with writes disabled shows whether the enable is obeyed. A long stretch of interleaved reads, writes and disabled writes on scattered addresses samples the read ports just before each edge, which tells read-old-value behaviour apart from bypassing. A second reset held during requested writes checks both the asynchronous load and its priority over writes.

// File: rtl/idx_regfile_pkg.sv
package idx_regfile_pkg;

   // Construction of a read port's selection network
   typedef enum logic [0:0] {
      RD_MUX   = 1'b0,   // indexed multiplexer
      RD_ANDOR = 1'b1    // one-hot decode, AND-OR reduction
   } rd_style_e;

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/rf_entry.sv
module rf_entry #(
   parameter int unsigned         DATA_W   = 32,
   parameter logic [DATA_W-1:0]   INIT_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= INIT_VAL;
      else if (we)  q <= d;
   end

   // The first edge after reset release must still see the index value
   AST_RESET_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (q == INIT_VAL));                            // R5

   // An entry that is not selected must keep its word
   AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));                                           // R4

endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [DEPTH-1:0]  sel
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_sel
      assign sel[i] = en && (addr == ADDR_W'(i));
   end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
   import idx_regfile_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter rd_style_e   RD_STYLE = RD_MUX
) (
   input  logic [DEPTH-1:0][DATA_W-1:0] regs,
   input  logic [ADDR_W-1:0]            addr,
   output logic [DATA_W-1:0]            data
);

   if (RD_STYLE == RD_MUX) begin : g_mux
      assign data = regs[addr];
   end else begin : g_andor
      always_comb begin
         data = '0;
         for (int i = 0; i < DEPTH; i++) begin
            data = data | (regs[i] & {DATA_W{addr == ADDR_W'(i)}});
         end
      end
   end

endmodule

// File: rtl/idx_regfile.sv
module idx_regfile
   import idx_regfile_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned PROBE_IDX = 1,
   parameter rd_style_e   RD_STYLE  = RD_MUX,
   localparam int unsigned ADDR_W   = addr_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b,
   output logic [DATA_W-1:0] probe_data
);

   // ---------------- elaboration-time parameter checks ----------------
   if (DEPTH < 2) begin : g_chk_depth
      $error("idx_regfile: DEPTH must be at least 2");
   end
   if ((1 << ADDR_W) != DEPTH) begin : g_chk_pow2
      $error("idx_regfile: DEPTH must be a power of two");
   end
   if (PROBE_IDX >= DEPTH) begin : g_chk_probe
      $error("idx_regfile: PROBE_IDX outside the array");
   end
   if (DATA_W < ADDR_W) begin : g_chk_width
      $error("idx_regfile: DATA_W too narrow to hold every index");
   end

   // ---------------- write decode ----------------
   logic [DEPTH-1:0] wr_sel;

   rf_wr_decode #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) u_wr_decode (
      .en   (wr_en),
      .addr (wr_addr),
      .sel  (wr_sel)
   );

   // ---------------- storage, entry i resets to i ----------------
   logic [DEPTH-1:0][DATA_W-1:0] store;

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      rf_entry #(
         .DATA_W   (DATA_W),
         .INIT_VAL (DATA_W'(i))
      ) u_entry (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_sel[i]),
         .d     (wr_data),
         .q     (store[i])
      );
   end

   // ---------------- read ports ----------------
   rf_read_port #(
      .DATA_W   (DATA_W),
      .DEPTH    (DEPTH),
      .ADDR_W   (ADDR_W),
      .RD_STYLE (RD_STYLE)
   ) u_rd_a (
      .regs (store),
      .addr (rd_addr_a),
      .data (rd_data_a)
   );

   rf_read_port #(
      .DATA_W   (DATA_W),
      .DEPTH    (DEPTH),
      .ADDR_W   (ADDR_W),
      .RD_STYLE (RD_STYLE)
   ) u_rd_b (
      .regs (store),
      .addr (rd_addr_b),
      .data (rd_data_b)
   );

   assign probe_data = store[PROBE_IDX];

   // ---------------- assertions ----------------
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data))));  // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(probe_data));                                               // R4

   AST_PROBE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_b == ADDR_W'(PROBE_IDX)) |-> (rd_data_b == probe_data));              // R6

   AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));                        // R2

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));                                                             // R3

endmodule

// File: tb/tb_idx_regfile.sv
module tb_idx_regfile;

   localparam int AW = 5;
   localparam int DW = 32;
   localparam int N  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [AW-1:0] rd_addr_a = '0;
   logic [AW-1:0] rd_addr_b = '0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] rd_data_a, rd_data_b, probe_data;

   int total = 0;
   int failed = 0;
   bit done = 1'b0;

   logic [DW-1:0] model [N];

   always #5 clk = ~clk;   // 100 MHz

   idx_regfile dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_addr_a  (rd_addr_a),
      .rd_addr_b  (rd_addr_b),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_en      (wr_en),
      .rd_data_a  (rd_data_a),
      .rd_data_b  (rd_data_b),
      .probe_data (probe_data)
   );

   function automatic logic [DW-1:0] pat(input int k, input logic [DW-1:0] salt);
      return (DW'(k) * 32'h9E37_79B1) ^ salt;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reset_model();
      for (int i = 0; i < N; i++) model[i] = DW'(i);
   endtask

   // Read every entry on both ports, the two walking in opposite directions
   task automatic read_all(input string req);
      for (int i = 0; i < N; i++) begin
         rd_addr_a = AW'(i);
         rd_addr_b = AW'(N - 1 - i);
         #1;
         chk(req, rd_data_a, model[i]);
         chk(req, rd_data_b, model[N - 1 - i]);
      end
   endtask

   initial begin
      // R5: assert reset asynchronously while writes are requested
      #3 rst_n = 1'b0;
      #1;
      reset_model();
      rd_addr_a = AW'(7);
      #1 chk("R5 async load before any edge", rd_data_a, 32'd7);
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(c + 2); wr_data = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      wr_en = 1'b0;
      #2 rst_n = 1'b1;

      // R1 / R5: index values everywhere; R6 probe shows entry 1
      @(negedge clk);
      read_all("R5 R1 reset index value");
      chk("R6 probe after reset", probe_data, 32'd1);

      // Write sweep: R3, R7 (entry 0), R8 (old value before the edge), R6
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i, 32'h0000_A5A5);
         rd_addr_a = AW'(i);
         #1 chk("R8 old value before write edge", rd_data_a, model[i]);
         chk("R6 probe during sweep", probe_data, model[1]);
         @(posedge clk);
         model[i] = pat(i, 32'h0000_A5A5);
         #1 chk("R8 new value after write edge", rd_data_a, model[i]);
      end
      @(negedge clk);
      wr_en = 1'b0;
      read_all("R3 write sweep readback");
      rd_addr_b = AW'(0);
      #1 chk("R7 entry 0 holds written word", rd_data_b, pat(0, 32'h0000_A5A5));
      chk("R6 probe after sweep", probe_data, pat(1, 32'h0000_A5A5));

      // R4: disabled writes to every address leave the array untouched
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         wr_en = 1'b0; wr_addr = AW'(i); wr_data = ~pat(i, 32'h0000_A5A5);
      end
      @(negedge clk);
      read_all("R4 disabled write ignored");
      chk("R4 probe unchanged", probe_data, model[1]);

      // R2 / R3 / R4 / R8: interleaved traffic on scattered addresses
      for (int k = 0; k < 512; k++) begin
         @(negedge clk);
         rd_addr_a = AW'((k * 7) % N);
         rd_addr_b = AW'((k * 13 + 5) % N);
         wr_addr   = AW'((k * 11 + 3) % N);
         wr_data   = pat(k, 32'h1234_0000);
         wr_en     = (k % 3) != 0;
         #1;
         chk("R2 R8 port A mixed traffic", rd_data_a, model[(k * 7) % N]);
         chk("R2 R8 port B mixed traffic", rd_data_b, model[(k * 13 + 5) % N]);
         chk("R6 probe mixed traffic", probe_data, model[1]);
         @(posedge clk);
         if ((k % 3) != 0) model[(k * 11 + 3) % N] = pat(k, 32'h1234_0000);
      end
      @(negedge clk);
      wr_en = 1'b0;
      read_all("R3 R4 mixed traffic final state");

      // R5: second reset held across edges with a write requested
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(1); wr_data = 32'hDEAD_BEEF;
      rd_addr_a = AW'(9);
      #2 rst_n = 1'b0;
      reset_model();
      #1 chk("R5 immediate load on falling reset", rd_data_a, 32'd9);
      @(posedge clk);
      #1 chk("R5 reset beats write to entry 1", probe_data, 32'd1);
      @(negedge clk);
      wr_en = 1'b0;
      #2 rst_n = 1'b1;
      @(negedge clk);
      read_all("R5 R1 second reset index value");

      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         failed++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

endmodule